// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block sits on the master side of an asynchronous bus and decides how each bus cycle ends. While the address strobe is high it watches three control inputs: a device acknowledge, a bus-error input and a halt input. It resolves their relative timing into one of six endings:

- normal
- halted
- bus error
- late bus error
- retry
- late retry

It reports the ending with a one-clock termination pulse and a 3-bit code. A built-in watchdog supplies an internal bus error when no acknowledge arrives within a programmable number of clocks, so that an access to unpopulated address space still completes.

The surrounding sequencer uses the outputs directly:
- `excp_req` starts exception handling.
- `halt_hold` keeps the next cycle from starting while halt is held after a halted or retry ending, which gives single-cycle stepping.
- `retry_req` tells the sequencer to re-run the same cycle once halt is released.

There is no data stream at this block's edge. All pins are plain control and status levels or pulses, with no valid/ready handshake and no back-pressure.

All inputs change away from the sampling clock edge. Signals asserted together are therefore seen on the same edge. The strobe must go low for at least one clock between two cycles.

Top module: `bus_term_ctrl`

## Requirements
- R1: Acknowledge sampled with bus error and halt negated, and no bus error on the following edge, ends with code 1, two clocks after the acknowledge edge.
- R2: Halt sampled at or before the acknowledge edge, with no bus error on the following edge, ends with code 2. After a code 2, 5 or 6, `halt_hold` stays high for as long as the halt input stays high.
- R3: Bus error sampled before any acknowledge, with no halt seen in the cycle, ends with code 3 one clock later. `excp_req` pulses with codes 3 and 4 only.
- R4: Bus error sampled on the edge just after the acknowledge edge, with no halt at or before the acknowledge, ends with code 4.
- R5: Bus error sampled before any acknowledge, with halt seen at any earlier or the same edge of the cycle, ends with code 5.
- R6: Bus error sampled on the edge after the acknowledge edge, with halt seen at or before either edge, ends with code 6.
- R7: After a code 5 or 6, `retry_req` pulses once for one clock, on the edge at which halt is first sampled negated.
- R8: With no usable acknowledge and no bus error, an internal bus error is raised TIMEOUT clocks after the first edge inside the cycle. The result is code 3, or code 5 when halt was seen.
- R9: An acknowledge or bus error already high at the edge that sees the strobe rise is ignored. It is honoured only after it has been sampled low within the current cycle.
- R10: `term_valid` is high for exactly one clock per terminated cycle. `term_code` is 0 whenever `term_valid` is low, and lies in 1..6 when it is high. All outputs are low after reset.
- R11: A strobe that falls before any termination abandons the cycle with no termination pulse, and the next cycle starts cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Address strobe, high for the duration of a bus cycle |
| dev_ack | input | 1 | Device acknowledge, active high |
| dev_berr | input | 1 | External bus error, active high |
| dev_halt | input | 1 | Halt request, active high |
| term_valid | output | 1 | One-clock pulse when the cycle's ending is decided |
| term_code | output | 3 | Ending: 1 normal, 2 halted, 3 bus error, 4 late bus error, 5 retry, 6 late retry, 0 none |
| excp_req | output | 1 | One-clock exception request, with codes 3 and 4 |
| retry_req | output | 1 | One-clock request to re-run the cycle once halt is released |
| halt_hold | output | 1 | High while a halted or retry ending keeps the next cycle waiting |

## Verification
The bound checker watches the following on every clock:
- the code encoding and the single-clock width of the termination pulse;
- that exception requests pair only with the two bus-error codes;
- that a retry request comes only after halt has been sampled low;
- that `halt_hold` never outlives halt;
- that no cycle stays open longer than the watchdog allows;
- that a pair of stale acknowledge and bus-error levels at strobe start yields no immediate ending.

Only the bench scenarios can show the following:
- that each ordering of acknowledge, bus error and halt lands on the right one of the six codes at the right clock;
- that the one-edge late window separates codes 4 and 6 from codes 1 and 2;
- that a stale acknowledge is re-armed by a low sample;
- that an abandoned cycle leaves no trace.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    TC_NONE       = 3'd0,
    TC_NORMAL     = 3'd1,
    TC_HALT       = 3'd2,
    TC_BERR       = 3'd3,
    TC_BERR_LATE  = 3'd4,
    TC_RETRY      = 3'd5,
    TC_RETRY_LATE = 3'd6
  } term_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_LATE,
    ST_TAIL
  } seq_state_e;

endpackage

// File: rtl/bt_qualify.sv
// Filters stale levels: an input counts only after it was seen low
// within the current strobe period.
module bt_qualify #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [N-1:0] raw,
  output logic [N-1:0] eff
);

  logic [N-1:0] armed;

  for (genvar i = 0; i < N; i++) begin : g_arm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed[i] <= 1'b0;
      else        armed[i] <= strobe ? (armed[i] | ~raw[i]) : 1'b0;
    end
    assign eff[i] = raw[i] & armed[i];
  end

endmodule

// File: rtl/bt_monitor.sv
// Bus watchdog: counts clocks while the cycle waits for a response.
module bt_monitor #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int unsigned CW   = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expire)  cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);

endmodule

// File: rtl/bt_classify.sv
// Sequencer that resolves acknowledge / bus error / halt timing
// into one of six ending codes.
module bt_classify
  import bus_term_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              ack_ok,
  input  logic              berr_ok,
  input  logic              halt,
  input  logic              tmo,
  output logic              run,
  output logic              term_valid,
  output logic [CODE_W-1:0] term_code,
  output logic              excp_req,
  output logic              retry_req,
  output logic              halt_hold
);

  seq_state_e st, st_n;
  term_code_e code_c;
  logic       decide;
  logic       hseen, h_at_ack;
  logic       pend_hold, pend_retry;
  logic       is_hold_code, is_retry_code, is_berr_code;

  always_comb begin
    decide = 1'b0;
    code_c = TC_NONE;
    st_n   = st;
    unique case (st)
      ST_IDLE: if (strobe) st_n = ST_ACTIVE;
      ST_ACTIVE: begin
        if (!strobe) begin
          st_n = ST_IDLE;
        end else if (berr_ok || tmo) begin
          decide = 1'b1;
          code_c = (halt || hseen) ? TC_RETRY : TC_BERR;
        end else if (ack_ok) begin
          st_n = ST_LATE;
        end
      end
      ST_LATE: begin
        decide = 1'b1;
        if (berr_ok) code_c = (h_at_ack || halt) ? TC_RETRY_LATE : TC_BERR_LATE;
        else         code_c = h_at_ack ? TC_HALT : TC_NORMAL;
      end
      ST_TAIL: if (!strobe && !(pend_hold && halt)) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
    if (decide) st_n = ST_TAIL;
  end

  assign is_hold_code  = (code_c == TC_HALT) || (code_c == TC_RETRY) ||
                         (code_c == TC_RETRY_LATE);
  assign is_retry_code = (code_c == TC_RETRY) || (code_c == TC_RETRY_LATE);
  assign is_berr_code  = (code_c == TC_BERR) || (code_c == TC_BERR_LATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      term_valid <= 1'b0;
      term_code  <= '0;
      excp_req   <= 1'b0;
      retry_req  <= 1'b0;
      hseen      <= 1'b0;
      h_at_ack   <= 1'b0;
      pend_hold  <= 1'b0;
      pend_retry <= 1'b0;
    end else begin
      st         <= st_n;
      term_valid <= decide;
      term_code  <= code_c;
      excp_req   <= decide && is_berr_code;
      retry_req  <= 1'b0;

      if (st == ST_ACTIVE) hseen <= hseen | halt;
      else                 hseen <= 1'b0;

      if (st == ST_ACTIVE && ack_ok) h_at_ack <= halt || hseen;

      if (decide) begin
        pend_hold  <= is_hold_code;
        pend_retry <= is_retry_code;
      end else if (st == ST_TAIL) begin
        if (pend_retry && !halt) begin
          retry_req  <= 1'b1;
          pend_retry <= 1'b0;
        end
        if (st_n == ST_IDLE) pend_hold <= 1'b0;
      end
    end
  end

  assign run       = (st == ST_ACTIVE);
  assign halt_hold = (st == ST_TAIL) && pend_hold && halt;

endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import bus_term_pkg::*;
#(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              dev_ack,
  input  logic              dev_berr,
  input  logic              dev_halt,
  output logic              term_valid,
  output logic [CODE_W-1:0] term_code,
  output logic              excp_req,
  output logic              retry_req,
  output logic              halt_hold
);

  localparam int unsigned NQ = 2;

  logic [NQ-1:0] q_raw, q_eff;
  logic          run, tmo;

  initial begin
    if (TIMEOUT < 2) $error("TIMEOUT must be at least 2");
  end

  assign q_raw = {dev_berr, dev_ack};

  bt_qualify #(.N(NQ)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .raw    (q_raw),
    .eff    (q_eff)
  );

  bt_monitor #(.TIMEOUT(TIMEOUT)) u_mon (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .expire (tmo)
  );

  bt_classify u_cls (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .ack_ok     (q_eff[0]),
    .berr_ok    (q_eff[1]),
    .halt       (dev_halt),
    .tmo        (tmo),
    .run        (run),
    .term_valid (term_valid),
    .term_code  (term_code),
    .excp_req   (excp_req),
    .retry_req  (retry_req),
    .halt_hold  (halt_hold)
  );

endmodule

// File: rtl/bus_term_chk.sv
module bus_term_chk #(
  parameter int unsigned TIMEOUT = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe,
  input logic       dev_ack,
  input logic       dev_berr,
  input logic       dev_halt,
  input logic       term_valid,
  input logic [2:0] term_code,
  input logic       excp_req,
  input logic       retry_req,
  input logic       halt_hold
);

  int   open_cnt;
  logic done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_cnt <= 0;
      done     <= 1'b0;
    end else if (!strobe) begin
      open_cnt <= 0;
      done     <= 1'b0;
    end else begin
      if (term_valid) done <= 1'b1;
      if (!done && !term_valid && open_cnt < int'(TIMEOUT) + 4)
        open_cnt <= open_cnt + 1;
    end
  end

  p_code_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |-> (term_code >= 3'd1 && term_code <= 3'd6));

  p_code_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !term_valid |-> term_code == 3'd0);

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |=> !term_valid);

  p_excp_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    excp_req |-> term_valid && (term_code == 3'd3 || term_code == 3'd4));

  p_retry_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> !$past(dev_halt));

  p_hold_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_hold |-> dev_halt);

  p_timeout_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !done) |-> open_cnt <= int'(TIMEOUT) + 1);

  p_stale_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(strobe) && dev_ack && dev_berr) |=> ##1 !term_valid);

endmodule

bind bus_term_ctrl bus_term_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strobe     (strobe),
  .dev_ack    (dev_ack),
  .dev_berr   (dev_berr),
  .dev_halt   (dev_halt),
  .term_valid (term_valid),
  .term_code  (term_code),
  .excp_req   (excp_req),
  .retry_req  (retry_req),
  .halt_hold  (halt_hold)
);

// File: tb/test_bus_term_ctrl.sv
module test_bus_term_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 64;
  localparam int NV         = 999;
  localparam int NVEC       = 15;

  typedef struct packed {
    int a_at;
    int b_at;
    int h_at;
    int code;
    int when;
  } vec_t;

  // a_at/b_at/h_at: negedge index (strobe at 0) where the input rises
  localparam vec_t VECS [NVEC] = '{
    '{1,  NV, NV, 1, 3},        // R1 plain acknowledge
    '{1,  NV, 1,  2, 3},        // R2 halt with ack
    '{3,  NV, 1,  2, 5},        // R2 halt before ack
    '{NV, 1,  NV, 3, 2},        // R3 berr instead of ack
    '{1,  1,  NV, 3, 2},        // R3 berr with ack
    '{3,  1,  NV, 3, 2},        // R3 berr before ack
    '{1,  2,  NV, 4, 3},        // R4 berr after ack
    '{NV, 1,  1,  5, 2},        // R5 halt+berr instead of ack
    '{2,  1,  1,  5, 2},        // R5 halt+berr before ack
    '{1,  2,  1,  6, 3},        // R6 halt with ack, late berr
    '{1,  2,  2,  6, 3},        // R6 both after ack
    '{NV, NV, NV, 3, TMO + 1},  // R8 watchdog
    '{NV, NV, 1,  5, TMO + 1},  // R8 watchdog with halt
    '{0,  NV, NV, 3, TMO + 1},  // R9 stale ack never re-armed
    '{1,  NV, 2,  1, 3}         // R1 halt only after ack
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0, dev_ack = 1'b0, dev_berr = 1'b0, dev_halt = 1'b0;
  logic       term_valid, excp_req, retry_req, halt_hold;
  logic [2:0] term_code;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_term_ctrl #(.TIMEOUT(TMO)) i_bus_term_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .dev_ack    (dev_ack),
    .dev_berr   (dev_berr),
    .dev_halt   (dev_halt),
    .term_valid (term_valid),
    .term_code  (term_code),
    .excp_req   (excp_req),
    .retry_req  (retry_req),
    .halt_hold  (halt_hold)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic string req_of(input int code);
    case (code)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input vec_t v, input int k);
    if (v.a_at == k) dev_ack  = 1'b1;
    if (v.b_at == k) dev_berr = 1'b1;
    if (v.h_at == k) dev_halt = 1'b1;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int    t;
    bit    got;
    int    c, e;
    string rq, rt;
    got = 1'b0; t = 0; c = 0; e = 0;
    rq = req_of(v.code);
    rt = (v.when > 10) ? "R8" : rq;
    @(negedge clk);
    strobe = 1'b1;
    apply(v, 0);
    for (int k = 1; k <= 90 && !got; k++) begin
      @(negedge clk);
      if (term_valid) begin
        got = 1'b1; t = k; c = int'(term_code); e = int'(excp_req);
      end else begin
        apply(v, k);
      end
    end
    chk($sformatf("%s vec%0d code", rq, idx), c, v.code);
    chk($sformatf("%s vec%0d timing", rt, idx), t, v.when);
    chk($sformatf("R3 vec%0d excp_req", idx), e,
        (v.code == 3 || v.code == 4) ? 1 : 0);
    dev_ack = 1'b0; dev_berr = 1'b0;
    @(negedge clk);
    chk($sformatf("R10 vec%0d single pulse", idx), int'(term_valid), 0);
    chk($sformatf("R2 vec%0d halt_hold", idx), int'(halt_hold),
        (v.code == 2 || v.code >= 5) ? 1 : 0);
    dev_halt = 1'b0; strobe = 1'b0;
    @(negedge clk);
    chk($sformatf("R7 vec%0d retry_req", idx), int'(retry_req),
        (v.code >= 5) ? 1 : 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    chk("R10 reset term_valid", int'(term_valid), 0);
    chk("R10 reset term_code", int'(term_code), 0);
    chk("R10 reset excp/retry/hold", int'({excp_req, retry_req, halt_hold}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

    // R9: stale ack, dropped at 2 and raised again at 3 -> code 1 at 5
    @(negedge clk);
    strobe = 1'b1; dev_ack = 1'b1;
    seen = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (term_valid && seen == 0) begin
        seen = k;
        chk("R9 re-armed ack code", int'(term_code), 1);
      end
      if (k == 2) dev_ack = 1'b0;
      if (k == 3) dev_ack = 1'b1;
    end
    chk("R9 re-armed ack timing", seen, 5);
    dev_ack = 1'b0; strobe = 1'b0;
    repeat (3) @(negedge clk);

    // R11: abandoned cycle produces no pulse, later cycle is normal
    @(negedge clk);
    strobe = 1'b1;
    seen = 0;
    for (int k = 1; k <= TMO + 10; k++) begin
      @(negedge clk);
      if (term_valid) seen++;
      if (k == 3) strobe = 1'b0;
    end
    chk("R11 abandoned cycle pulses", seen, 0);
    run_vec(VECS[0], 100);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule